// File: doc/BRIEF.md
# Reference Clock Cycle-by-Cycle Period Monitor

This block watches a reference clock, one cycle at a time, for a period that is too short or too long, and for an edge that never arrives. It receives the reference as a one-cycle pulse per rising edge, already synchronized into the system clock domain. It also receives the expected period, in system clock counts. It counts system clocks from one reference edge to the next and judges each measured interval on its own against a window that spans half to one and a half times the expected period.

A failure sets a flag that stays set until software-side logic pulses a clear input. Each failing interval also produces a single-cycle event pulse. When the count passes the upper bound of the window and no edge has arrived, the monitor reports the failure at once and does not wait for the late edge. Monitoring runs without pause for as long as the enable is high, whether or not the reference is already trusted.

Top module: `cycleCheck`

## Requirements
- R1: After reset, `failFlag` and `failPulse` are both 0.
- R2: The period is the number of system clock rising edges from the one that samples a `refEdge` pulse to the one that samples the next pulse. A period P with `nominal>>1` <= P <= `nominal + (nominal>>1)` passes, and produces no pulse and no change to the flag.
- R3: A period shorter than `nominal>>1` is a failure. `failPulse` is high for the one cycle after the clock edge that samples the closing `refEdge`, and `failFlag` becomes 1 at that same point.
- R4: An edge that closes a period of exactly `nominal + (nominal>>1) + 1` is a failure. It is reported one cycle after that edge.
- R5: If no edge arrives, a failure is reported one cycle after the clock edge at which the running count reaches `nominal + (nominal>>1) + 1`. The monitor does not wait for the late edge.
- R6: The first `refEdge` after enable rises, and the first after any failure, only starts the timing of a period. Whatever interval precedes it, it is not judged.
- R7: `failFlag` stays 1 until `clearFail` is sampled high. If a failure and `clearFail` fall in the same cycle, the flag stays 1.
- R8: Each failing period produces exactly one single-cycle `failPulse`.
- R9: While `enable` is low, no failure is reported and the period timing is abandoned. `failFlag` keeps its value.
- R10: Judging repeats for every period, back to back, for any `nominal` value set while the monitor is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Monitor enable; low abandons timing |
| refEdge | input | 1 | One-cycle pulse per reference rising edge, synchronous to clk |
| nominal | input | CNT_W | Expected reference period in system clock counts |
| clearFail | input | 1 | Clears the sticky failure flag |
| failFlag | output | 1 | Sticky failure indication |
| failPulse | output | 1 | One-cycle pulse per failing period |

## Verification
The assertions check on every cycle that the flag is sticky, that a pulse always comes with the flag, that pulses never last two cycles in a row, that nothing fires while disabled, and that a pulse never follows a cycle spent waiting for a first edge. Only the bench scenarios can show the exact window boundaries: a period equal to either limit passes, and one count beyond fails. They also show that a missing edge is reported in the precise cycle the count exceeds the upper bound, that a clear racing a new failure leaves the flag set, and that the limits follow a changed nominal value.

// File: rtl/cycleCheckPkg.sv
package cycleCheckPkg;

  typedef enum logic [1:0] {
    MON_IDLE = 2'd0,
    MON_ARM  = 2'd1,
    MON_RUN  = 2'd2
  } monState_t;

  // strobes from control to the period counter
  typedef struct packed {
    logic hold0;    // keep count at zero
    logic restart;  // a period starts: count becomes one
  } cntStrobe_t;

endpackage

// File: rtl/cycleCheckPath.sv
module cycleCheckPath
  import cycleCheckPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] nominal,
  output logic             periodShort,
  output logic             periodLong
);

  localparam int LIM_W = CNT_W + 1;
  localparam logic [LIM_W-1:0] SAT_VAL = '1;

  logic [LIM_W-1:0] elapsed;
  logic [LIM_W-1:0] nomWide;
  logic [LIM_W-1:0] shortLim;
  logic [LIM_W-1:0] longLim;

  always_comb begin
    nomWide  = {1'b0, nominal};
    shortLim = nomWide >> 1;
    longLim  = nomWide + (nomWide >> 1);
  end

  // elapsed system clocks since the last accepted reference edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsed <= '0;
    end else if (strobe.hold0) begin
      elapsed <= '0;
    end else if (strobe.restart) begin
      elapsed <= LIM_W'(1);
    end else if (elapsed != SAT_VAL) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign periodShort = (elapsed < shortLim);
  assign periodLong  = (elapsed > longLim);

endmodule

// File: rtl/cycleCheckCtrl.sv
module cycleCheckCtrl
  import cycleCheckPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       refEdge,
  input  logic       clearFail,
  input  logic       periodShort,
  input  logic       periodLong,
  output cntStrobe_t strobe,
  output logic       failFlag,
  output logic       failPulse
);

  monState_t state, stateNext;
  logic      failNow;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    failNow   = 1'b0;
    case (state)
      MON_IDLE: begin
        strobe.hold0 = 1'b1;
        if (enable) stateNext = MON_ARM;
      end
      MON_ARM: begin
        if (!enable) begin
          stateNext    = MON_IDLE;
          strobe.hold0 = 1'b1;
        end else if (refEdge) begin
          stateNext      = MON_RUN;
          strobe.restart = 1'b1;
        end
      end
      MON_RUN: begin
        if (!enable) begin
          stateNext    = MON_IDLE;
          strobe.hold0 = 1'b1;
        end else if (periodLong || (refEdge && periodShort)) begin
          failNow   = 1'b1;
          stateNext = MON_ARM;
        end else if (refEdge) begin
          strobe.restart = 1'b1;
        end
      end
      default: begin
        stateNext    = MON_IDLE;
        strobe.hold0 = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= MON_IDLE;
      failPulse <= 1'b0;
      failFlag  <= 1'b0;
    end else begin
      state     <= stateNext;
      failPulse <= failNow;
      failFlag  <= failNow | (failFlag & ~clearFail);
    end
  end

  // R7: an event is always visible on the sticky flag
  p_flag_with_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |-> failFlag);

  // R7: the flag only drops through clearFail
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !clearFail) |=> failFlag);

  // R8: one cycle per failing period
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |=> !failPulse);

  // R9: nothing reported while disabled
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !failPulse);

  // R6: waiting for a first edge never yields a failure
  p_first_edge_unjudged_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == MON_ARM) |=> !failPulse);

endmodule

// File: rtl/cycleCheck.sv
module cycleCheck
  import cycleCheckPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             refEdge,
  input  logic [CNT_W-1:0] nominal,
  input  logic             clearFail,
  output logic             failFlag,
  output logic             failPulse
);

  cntStrobe_t cntStrobe;
  logic       periodShort;
  logic       periodLong;

  cycleCheckCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .refEdge    (refEdge),
    .clearFail  (clearFail),
    .periodShort(periodShort),
    .periodLong (periodLong),
    .strobe     (cntStrobe),
    .failFlag   (failFlag),
    .failPulse  (failPulse)
  );

  cycleCheckPath #(.CNT_W(CNT_W)) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (cntStrobe),
    .nominal    (nominal),
    .periodShort(periodShort),
    .periodLong (periodLong)
  );

endmodule

// File: tb/cycleCheck_tb_top.sv
module cycleCheck_tb_top;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             refEdge = 1'b0;
  logic             clearFail = 1'b0;
  logic [CNT_W-1:0] nominal = 16'd20;
  logic             failFlag;
  logic             failPulse;

  typedef struct {
    int    at;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastEdge = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cycleCheck #(.CNT_W(CNT_W)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .refEdge  (refEdge),
    .nominal  (nominal),
    .clearFail(clearFail),
    .failFlag (failFlag),
    .failPulse(failPulse)
  );

  task automatic check(string req, logic actual, logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, actual, expected, cyc);
    end
  endtask

  // idle p-1 cycles, then one edge pulse: the edge closes a period of p
  task automatic sendEdge(int p, bit expFail = 1'b0, string req = "", bit clr = 1'b0);
    expItem_t item;
    if (expFail) begin
      item.at  = lastEdge + p;
      item.req = req;
      expQ.push_back(item);
    end
    repeat (p - 1) @(negedge clk);
    refEdge   = 1'b1;
    clearFail = clr;
    @(negedge clk);
    refEdge   = 1'b0;
    clearFail = 1'b0;
    lastEdge  = cyc;
  endtask

  task automatic startMon();
    enable = 1'b1;
    @(negedge clk);
    sendEdge(1);  // first edge: only starts timing
  endtask

  task automatic pulseClear();
    clearFail = 1'b1;
    @(negedge clk);
    clearFail = 1'b0;
  endtask

  // scoreboard monitor: every pulse must match the oldest expectation
  always @(negedge clk) begin
    if (rstN && failPulse) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected pulse actual=cycle %0d expected=none", cyc);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (e.at != cyc) begin
          errors++;
          $display("FAIL %s pulse actual=cycle %0d expected=cycle %0d", e.req, cyc, e.at);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flag", failFlag, 1'b0);
    check("R1 pulse", failPulse, 1'b0);

    // nominal 20: window 10..30
    startMon();
    sendEdge(20);
    sendEdge(10);
    sendEdge(30);
    check("R2 flag after in-window periods", failFlag, 1'b0);

    sendEdge(9, 1'b1, "R3");
    check("R3 flag set", failFlag, 1'b1);

    sendEdge(3);   // R6: first edge after failure not judged
    sendEdge(20);
    sendEdge(11);

    sendEdge(31, 1'b1, "R4");
    sendEdge(2);   // R6 restart
    sendEdge(25);

    begin
      expItem_t item;
      item.at  = lastEdge + 31;
      item.req = "R5";
      expQ.push_back(item);
    end
    repeat (45) @(negedge clk);
    check("R5 flag after missing edge", failFlag, 1'b1);
    sendEdge(1);   // restart after failure
    sendEdge(20);

    // R9: disabled, short periods ignored, flag kept
    enable = 1'b0;
    repeat (4) sendEdge(3);
    sendEdge(60);
    check("R9 flag kept while disabled", failFlag, 1'b1);

    pulseClear();
    check("R7 flag cleared", failFlag, 1'b0);

    // R10: nominal 8, window 4..12
    nominal = 16'd8;
    @(negedge clk);
    startMon();
    sendEdge(4);
    sendEdge(12);
    sendEdge(8);
    check("R10 flag after in-window periods", failFlag, 1'b0);
    sendEdge(3, 1'b1, "R10");
    check("R10 flag set on short period", failFlag, 1'b1);

    pulseClear();
    check("R7 flag cleared again", failFlag, 1'b0);
    sendEdge(5);   // restart
    sendEdge(13, 1'b1, "R7", 1'b1);  // clear races failure
    check("R7 failure wins over clear", failFlag, 1'b1);
    @(negedge clk);
    check("R8 pulse lasts one cycle", failPulse, 1'b0);

    repeat (20) @(negedge clk);
    while (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      errors++;
      $display("FAIL %s pulse actual=none expected=cycle %0d", e.req, e.at);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule